// File: doc/BRIEF.md
# Host Register File with General-Purpose Port

This block is the control register file of a video encoder. A host reaches it in one of two ways. The first is a parallel port: a chip select, a read/write line and an address/data select, with the bytes carried on the shared data pins. The second is a set of register strobes that a separate two-wire serial engine produces. The block holds fixed identification bytes, six writable mode registers, a read-only field indicator and a general-purpose port register. That port register combines three kinds of bit: pin levels mirrored on reads, latched outputs, and the live burst and composite-sync flags from the timing generator.

The block owns the eight shared data pins and drives them as separate output values and per-bit output enables. An input selects the port behaviour. In serial mode the upper two pins are inputs, the middle four continuously drive the latched port bits, and the low two continuously carry the live burst and sync flags. In parallel mode every pin is released, except in the cycles that return read data to the host.

Top module: `hostRegFile`

## Requirements
- R1: Reads of addresses 00h, 01h and 02h return 97h, 24h and 90h. Address 02h returns 91h when COPY_PROTECT is 1. Address 03h returns the REV_ID parameter (default 01h).
- R2: Registers 04h, 05h, 0Fh, 20h, 21h and 22h accept writes and read back what was written. They appear on modeGlobal, modeVideo, modeGeneral, ccByte1, ccByte2 and ccCtrl respectively. Bits 6 and 2 of register 0Fh are reserved: they always read 0 and stay 0 on the output.
- R3: Address 06h reads {2'b00, fieldId, 3'b000}, and writes to it are ignored. Any address outside those named in R1 to R4 reads 00h and ignores writes.
- R4: Bits 5:2 of register 0Eh are read/write. Writes to bits 7:6 of register 0Eh are ignored.
- R5: A serial-mode read of register 0Eh returns padIn[7:6] in bits 7:6, as sampled on the clock edge that takes the read strobe. A parallel-mode read returns 0 in those bits.
- R6: While read data from register 0Eh is being presented, bits 1 and 0 equal the current burstFlag and compSync inputs. They follow any change in those inputs without waiting for a clock.
- R7: In serial mode padOe is 3Fh. padOut[5:2] carries the latched register 0Eh bits 5:2, and padOut[1:0] carries {burstFlag, compSync}.
- R8: In parallel mode padOe is FFh and padOut carries the read data in each cycle that follows an edge sampling hostCs and hostRead both high. In every other parallel-mode cycle padOe and padOut are 00h.
- R9: Parallel protocol. An edge that samples hostCs=1, hostRead=0 and hostAddrSel=1 loads padIn into the address pointer. An edge that samples hostCs=1, hostRead=0 and hostAddrSel=0 writes padIn to the addressed register, which shows the new value after that edge. Read data is valid one clock after the read strobe.
- R10: Parallel-port strobes are ignored in serial mode, and the serial strobes are ignored in parallel mode.
- R11: Reset (rstN low) clears every writable register, the port latch, the address pointer and the read-data register to 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| serialMode | input | 1 | 1 selects serial-mode pin behaviour and the serial strobes |
| hostCs | input | 1 | Parallel chip select, active high |
| hostRead | input | 1 | Parallel direction, 1 = read, 0 = write |
| hostAddrSel | input | 1 | Parallel write target, 1 = address pointer, 0 = data |
| padIn | input | 8 | Levels seen on the shared data pins |
| padOut | output | 8 | Values driven onto the shared data pins |
| padOe | output | 8 | Per-pin output enable, 0 = high impedance |
| serWrStb | input | 1 | Serial engine register write strobe |
| serRdStb | input | 1 | Serial engine register read strobe |
| serAddr | input | 8 | Serial engine register address |
| serWrData | input | 8 | Serial engine write data |
| serRdData | output | 8 | Read data of the most recent read |
| burstFlag | input | 1 | Live burst flag |
| compSync | input | 1 | Live composite sync, low during sync tips |
| fieldId | input | 3 | Current field indicator |
| modeGlobal | output | 8 | Register 04h |
| modeVideo | output | 8 | Register 05h |
| modeGeneral | output | 8 | Register 0Fh |
| ccByte1 | output | 8 | Register 20h |
| ccByte2 | output | 8 | Register 21h |
| ccCtrl | output | 8 | Register 22h |

## Verification
The assertions assume that every input is known from time zero. They also assume that the host never reads a register on the same edge that writes it, and that serialMode changes only between host operations, never while a strobe is active. The bench's tasks issue one parallel or serial operation at a time and switch mode only at an operation boundary. Random stimulus varies the address, the data, the mode, the live flags, the field indicator and the upper pin levels inside that discipline.

// File: rtl/hostRegPkg.sv
package hostRegPkg;
  localparam int DW = 8;
  localparam int NUM_MODE = 6;
  typedef logic [DW-1:0] regByte_t;

  localparam regByte_t ADDR_ID2   = 8'h00;
  localparam regByte_t ADDR_ID1   = 8'h01;
  localparam regByte_t ADDR_ID0   = 8'h02;
  localparam regByte_t ADDR_REV   = 8'h03;
  localparam regByte_t ADDR_FIELD = 8'h06;
  localparam regByte_t ADDR_GP    = 8'h0E;

  // Writable mode registers and the bits each one keeps
  localparam regByte_t MODE_ADDR [NUM_MODE] = '{8'h04, 8'h05, 8'h0F, 8'h20, 8'h21, 8'h22};
  localparam regByte_t MODE_MASK [NUM_MODE] = '{8'hFF, 8'hFF, 8'hBB, 8'hFF, 8'hFF, 8'hFF};

  // Strobes from control to datapath
  typedef struct packed {
    logic     wrEn;
    regByte_t wrAddr;
    regByte_t wrData;
    logic     rdEn;
    regByte_t rdAddr;
    logic     rdPar;
  } hostStb_t;
endpackage

// File: rtl/hostRegCtrl.sv
module hostRegCtrl
  import hostRegPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     serialMode,
  input  logic     hostCs,
  input  logic     hostRead,
  input  logic     hostAddrSel,
  input  regByte_t padIn,
  input  logic     serWrStb,
  input  logic     serRdStb,
  input  regByte_t serAddr,
  input  regByte_t serWrData,
  output hostStb_t stb
);
  regByte_t addrPtr;
  logic parPtrWr, parDataWr, parRd, serWr, serRd;

  assign parPtrWr  = !serialMode && hostCs && !hostRead && hostAddrSel;
  assign parDataWr = !serialMode && hostCs && !hostRead && !hostAddrSel;
  assign parRd     = !serialMode && hostCs && hostRead;
  assign serWr     = serialMode && serWrStb;
  assign serRd     = serialMode && serRdStb;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) addrPtr <= '0;
    else if (parPtrWr) addrPtr <= padIn;
  end

  always_comb begin
    stb.wrEn   = parDataWr || serWr;
    stb.wrAddr = serialMode ? serAddr : addrPtr;
    stb.wrData = serialMode ? serWrData : padIn;
    stb.rdEn   = parRd || serRd;
    stb.rdAddr = serialMode ? serAddr : addrPtr;
    stb.rdPar  = parRd;
  end

  // R10: in serial mode only the serial write strobe can write
  a_r10_par_blocked: assert property (@(posedge clk) disable iff (!rstN)
    (serialMode && !serWrStb) |-> !stb.wrEn);

  // R10: in parallel mode the serial read strobe alone starts no read
  a_r10_ser_blocked: assert property (@(posedge clk) disable iff (!rstN)
    (!serialMode && !hostCs) |-> !stb.rdEn);

  // R9: pointer cycle loads the pin byte
  a_r9_ptr_load: assert property (@(posedge clk) disable iff (!rstN)
    parPtrWr |=> (addrPtr == $past(padIn)));
endmodule

// File: rtl/hostRegData.sv
module hostRegData
  import hostRegPkg::*;
#(
  parameter regByte_t ID_HIGH = 8'h97,
  parameter regByte_t ID_MID  = 8'h24,
  parameter bit       COPY_PROTECT = 1'b0,
  parameter regByte_t REV_ID  = 8'h01
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       serialMode,
  input  hostStb_t   stb,
  input  logic [1:0] pinsHi,
  input  logic       burstFlag,
  input  logic       compSync,
  input  logic [2:0] fieldId,
  output regByte_t   padOut,
  output regByte_t   padOe,
  output regByte_t   serRdData,
  output logic [NUM_MODE-1:0][DW-1:0] modeRegs
);
  localparam regByte_t ID_LOW = COPY_PROTECT ? 8'h91 : 8'h90;

  logic [3:0] gpQ;
  regByte_t   rdNext, rdDataQ, liveData;
  logic       rdValidQ, rdParQ, rdIsGpQ;

  // Mode registers, one per table entry
  for (genvar g = 0; g < NUM_MODE; g++) begin : gMode
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) modeRegs[g] <= '0;
      else if (stb.wrEn && stb.wrAddr == MODE_ADDR[g])
        modeRegs[g] <= stb.wrData & MODE_MASK[g];
    end
  end

  // Latched port bits
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) gpQ <= '0;
    else if (stb.wrEn && stb.wrAddr == ADDR_GP) gpQ <= stb.wrData[5:2];
  end

  // Read selection
  always_comb begin
    rdNext = '0;
    case (stb.rdAddr)
      ADDR_ID2:   rdNext = ID_HIGH;
      ADDR_ID1:   rdNext = ID_MID;
      ADDR_ID0:   rdNext = ID_LOW;
      ADDR_REV:   rdNext = REV_ID;
      ADDR_FIELD: rdNext = {2'b00, fieldId, 3'b000};
      ADDR_GP:    rdNext = {(stb.rdPar ? 2'b00 : pinsHi), gpQ, 2'b00};
      default: begin
        for (int i = 0; i < NUM_MODE; i++)
          if (stb.rdAddr == MODE_ADDR[i]) rdNext = modeRegs[i];
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdDataQ  <= '0;
      rdValidQ <= 1'b0;
      rdParQ   <= 1'b0;
      rdIsGpQ  <= 1'b0;
    end else begin
      rdValidQ <= stb.rdEn;
      rdParQ   <= stb.rdPar;
      if (stb.rdEn) begin
        rdDataQ <= rdNext;
        rdIsGpQ <= (stb.rdAddr == ADDR_GP);
      end
    end
  end

  // Live flags replace the low bits of a port-register read
  assign liveData  = rdIsGpQ ? {rdDataQ[7:2], burstFlag, compSync} : rdDataQ;
  assign serRdData = liveData;

  // Pin ownership
  always_comb begin
    if (serialMode) begin
      padOe  = 8'h3F;
      padOut = {2'b00, gpQ, burstFlag, compSync};
    end else if (rdValidQ && rdParQ) begin
      padOe  = 8'hFF;
      padOut = liveData;
    end else begin
      padOe  = 8'h00;
      padOut = 8'h00;
    end
  end

  // R1: first identification byte returns its fixed value
  a_r1_id_high: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdEn && stb.rdAddr == ADDR_ID2) |=> (serRdData == ID_HIGH));

  // R3: field register has zero reserved bits
  a_r3_field_zero: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdEn && stb.rdAddr == ADDR_FIELD) |=>
      (serRdData[7:6] == 2'b00 && serRdData[2:0] == 3'b000));

  // R4: port write keeps only bits 5:2
  a_r4_gp_write: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrEn && stb.wrAddr == ADDR_GP) |=> (gpQ == $past(stb.wrData[5:2])));

  // R7: serial mode pin drive
  a_r7_serial_pins: assert property (@(posedge clk) disable iff (!rstN)
    serialMode |-> (padOe == 8'h3F && padOut[1:0] == {burstFlag, compSync}));

  // R8: parallel pins released when no read was taken
  a_r8_par_hiz: assert property (@(posedge clk) disable iff (!rstN)
    (!serialMode && !$past(stb.rdPar)) |-> (padOe == 8'h00));

  // R2: reserved bits of the general register never set
  a_r2_reserved: assert property (@(posedge clk) disable iff (!rstN)
    (modeRegs[2][6] == 1'b0 && modeRegs[2][2] == 1'b0));
endmodule

// File: rtl/hostRegFile.sv
module hostRegFile
  import hostRegPkg::*;
#(
  parameter logic [7:0] ID_HIGH = 8'h97,
  parameter logic [7:0] ID_MID  = 8'h24,
  parameter bit         COPY_PROTECT = 1'b0,
  parameter logic [7:0] REV_ID  = 8'h01
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       serialMode,
  input  logic       hostCs,
  input  logic       hostRead,
  input  logic       hostAddrSel,
  input  logic [7:0] padIn,
  output logic [7:0] padOut,
  output logic [7:0] padOe,
  input  logic       serWrStb,
  input  logic       serRdStb,
  input  logic [7:0] serAddr,
  input  logic [7:0] serWrData,
  output logic [7:0] serRdData,
  input  logic       burstFlag,
  input  logic       compSync,
  input  logic [2:0] fieldId,
  output logic [7:0] modeGlobal,
  output logic [7:0] modeVideo,
  output logic [7:0] modeGeneral,
  output logic [7:0] ccByte1,
  output logic [7:0] ccByte2,
  output logic [7:0] ccCtrl
);
  hostStb_t stb;
  logic [NUM_MODE-1:0][DW-1:0] modeRegs;

  hostRegCtrl uCtrl (
    .clk(clk), .rstN(rstN), .serialMode(serialMode),
    .hostCs(hostCs), .hostRead(hostRead), .hostAddrSel(hostAddrSel),
    .padIn(padIn), .serWrStb(serWrStb), .serRdStb(serRdStb),
    .serAddr(serAddr), .serWrData(serWrData), .stb(stb)
  );

  hostRegData #(
    .ID_HIGH(ID_HIGH), .ID_MID(ID_MID),
    .COPY_PROTECT(COPY_PROTECT), .REV_ID(REV_ID)
  ) uData (
    .clk(clk), .rstN(rstN), .serialMode(serialMode), .stb(stb),
    .pinsHi(padIn[7:6]), .burstFlag(burstFlag), .compSync(compSync),
    .fieldId(fieldId), .padOut(padOut), .padOe(padOe),
    .serRdData(serRdData), .modeRegs(modeRegs)
  );

  assign modeGlobal  = modeRegs[0];
  assign modeVideo   = modeRegs[1];
  assign modeGeneral = modeRegs[2];
  assign ccByte1     = modeRegs[3];
  assign ccByte2     = modeRegs[4];
  assign ccCtrl      = modeRegs[5];
endmodule

// File: tb/hostRegFile_test.sv
module hostRegFile_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serialMode = 1'b0, hostCs = 1'b0, hostRead = 1'b0, hostAddrSel = 1'b0;
  logic [7:0] padIn = 8'h00;
  logic [7:0] padOut, padOe, serRdData;
  logic serWrStb = 1'b0, serRdStb = 1'b0;
  logic [7:0] serAddr = 8'h00, serWrData = 8'h00;
  logic burstFlag = 1'b0, compSync = 1'b1;
  logic [2:0] fieldId = 3'd0;
  logic [7:0] modeGlobal, modeVideo, modeGeneral, ccByte1, ccByte2, ccCtrl;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [7:0] shReg [0:255];
  logic [3:0] gpSh;

  always #2 clk = ~clk;

  hostRegFile uut (
    .clk(clk), .rstN(rstN), .serialMode(serialMode), .hostCs(hostCs),
    .hostRead(hostRead), .hostAddrSel(hostAddrSel), .padIn(padIn),
    .padOut(padOut), .padOe(padOe), .serWrStb(serWrStb), .serRdStb(serRdStb),
    .serAddr(serAddr), .serWrData(serWrData), .serRdData(serRdData),
    .burstFlag(burstFlag), .compSync(compSync), .fieldId(fieldId),
    .modeGlobal(modeGlobal), .modeVideo(modeVideo), .modeGeneral(modeGeneral),
    .ccByte1(ccByte1), .ccByte2(ccByte2), .ccCtrl(ccCtrl)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] expRead(input logic [7:0] a, input logic par,
                                         input logic [1:0] pins);
    case (a)
      8'h00: return 8'h97;
      8'h01: return 8'h24;
      8'h02: return 8'h90;
      8'h03: return 8'h01;
      8'h06: return {2'b00, fieldId, 3'b000};
      8'h0E: return {(par ? 2'b00 : pins), gpSh, burstFlag, compSync};
      8'h04, 8'h05, 8'h0F, 8'h20, 8'h21, 8'h22: return shReg[a];
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] pickAddr(input int k);
    case (k % 16)
      0: return 8'h00;  1: return 8'h01;  2: return 8'h02;  3: return 8'h03;
      4: return 8'h04;  5: return 8'h05;  6: return 8'h06;  7: return 8'h0E;
      8: return 8'h0F;  9: return 8'h20; 10: return 8'h21; 11: return 8'h22;
      12: return 8'h07; 13: return 8'h10; 14: return 8'h30; default: return 8'hFF;
    endcase
  endfunction

  task automatic modelWrite(input logic [7:0] a, input logic [7:0] d);
    case (a)
      8'h04, 8'h05, 8'h20, 8'h21, 8'h22: shReg[a] = d;
      8'h0F: shReg[a] = d & 8'hBB;
      8'h0E: gpSh = d[5:2];
      default: ;
    endcase
  endtask

  task automatic chkModes(input string tag);
    chk({tag, " modeGlobal"}, modeGlobal, shReg[8'h04]);
    chk({tag, " modeVideo"}, modeVideo, shReg[8'h05]);
    chk({tag, " modeGeneral"}, modeGeneral, shReg[8'h0F]);
    chk({tag, " ccByte1"}, ccByte1, shReg[8'h20]);
    chk({tag, " ccByte2"}, ccByte2, shReg[8'h21]);
    chk({tag, " ccCtrl"}, ccCtrl, shReg[8'h22]);
  endtask

  // R9: pointer cycle then data cycle
  task automatic parWrite(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    serialMode = 1'b0; hostCs = 1'b1; hostRead = 1'b0; hostAddrSel = 1'b1; padIn = a;
    @(negedge clk);
    hostAddrSel = 1'b0; padIn = d;
    @(negedge clk);
    hostCs = 1'b0;
    modelWrite(a, d);
  endtask

  // R8 R9: read valid one clock after strobe, pins released after
  task automatic parRead(input logic [7:0] a, input string tag);
    @(negedge clk);
    serialMode = 1'b0; hostCs = 1'b1; hostRead = 1'b0; hostAddrSel = 1'b1; padIn = a;
    @(negedge clk);
    hostRead = 1'b1; hostAddrSel = 1'b0; padIn = 8'h00;
    @(negedge clk);
    chk({tag, " R8 padOe read"}, padOe, 8'hFF);
    chk({tag, " R9 padOut read"}, padOut, expRead(a, 1'b1, 2'b00));
    hostCs = 1'b0; hostRead = 1'b0;
    @(negedge clk);
    chk({tag, " R8 padOe idle"}, padOe, 8'h00);
    chk({tag, " R8 padOut idle"}, padOut, 8'h00);
  endtask

  task automatic serWrite(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    serialMode = 1'b1; serWrStb = 1'b1; serAddr = a; serWrData = d;
    @(negedge clk);
    serWrStb = 1'b0;
    modelWrite(a, d);
  endtask

  // R5: pins sampled at the strobe edge, then changed before the check
  task automatic serRead(input logic [7:0] a, input logic [1:0] pins, input string tag);
    logic [7:0] e;
    @(negedge clk);
    serialMode = 1'b1; serRdStb = 1'b1; serAddr = a; padIn[7:6] = pins;
    @(negedge clk);
    serRdStb = 1'b0; padIn[7:6] = ~pins;
    e = expRead(a, 1'b0, pins);
    #1;
    chk({tag, " R5 serRdData"}, serRdData, e);
    chk({tag, " R7 padOe"}, padOe, 8'h3F);
    chk({tag, " R7 padOut"}, padOut & 8'h3F, {2'b00, gpSh, burstFlag, compSync});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) shReg[i] = 8'h00;
    gpSh = 4'h0;
    repeat (3) @(negedge clk);
    // R11: reset state
    chkModes("R11 reset");
    chk("R11 padOe reset", padOe, 8'h00);
    chk("R11 serRdData reset", serRdData, 8'h00);
    rstN = 1'b1;
    @(negedge clk);

    // R1: identification bytes in both modes
    parRead(8'h00, "R1 id00");
    parRead(8'h01, "R1 id01");
    parRead(8'h02, "R1 id02");
    serRead(8'h03, 2'b00, "R1 rev");

    // R9: write takes effect on the edge that takes the strobe
    @(negedge clk);
    serialMode = 1'b0; hostCs = 1'b1; hostRead = 1'b0; hostAddrSel = 1'b1; padIn = 8'h04;
    @(negedge clk);
    hostAddrSel = 1'b0; padIn = 8'h5A;
    chk("R9 before write edge", modeGlobal, 8'h00);
    @(negedge clk);
    hostCs = 1'b0;
    modelWrite(8'h04, 8'h5A);
    chk("R9 after write edge", modeGlobal, 8'h5A);

    // R2: reserved bits of 0Fh
    parWrite(8'h0F, 8'hFF);
    parRead(8'h0F, "R2 reg0F");
    chkModes("R2 after 0F");

    // R3: field register and unmapped addresses
    fieldId = 3'd5;
    parWrite(8'h06, 8'hFF);
    parRead(8'h06, "R3 field");
    parWrite(8'h10, 8'hA5);
    parRead(8'h10, "R3 unmapped");
    serRead(8'h06, 2'b11, "R3 field serial");

    // R4 R5: port register in both modes
    parWrite(8'h0E, 8'hFF);
    parRead(8'h0E, "R4 R5 gp parallel");
    serRead(8'h0E, 2'b10, "R4 R5 gp serial");
    serWrite(8'h0E, 8'h14);
    serRead(8'h0E, 2'b01, "R4 gp serial write");

    // R6: live flags follow during a held parallel read
    @(negedge clk);
    serialMode = 1'b0; hostCs = 1'b1; hostRead = 1'b0; hostAddrSel = 1'b1; padIn = 8'h0E;
    @(negedge clk);
    hostRead = 1'b1; hostAddrSel = 1'b0;
    @(negedge clk);
    burstFlag = 1'b1; compSync = 1'b0;
    #1 chk("R6 live flags a", padOut, {2'b00, gpSh, 2'b10});
    burstFlag = 1'b0; compSync = 1'b1;
    #1 chk("R6 live flags b", padOut, {2'b00, gpSh, 2'b01});
    hostCs = 1'b0; hostRead = 1'b0;

    // R7: serial pins follow the flags without a read
    @(negedge clk);
    serialMode = 1'b1; burstFlag = 1'b1; compSync = 1'b0;
    #1 chk("R7 serial flags", padOut, {2'b00, gpSh, 2'b10});
    chk("R7 serial oe", padOe, 8'h3F);

    // R10: parallel strobes in serial mode, serial strobes in parallel mode
    @(negedge clk);
    serialMode = 1'b1; hostCs = 1'b1; hostRead = 1'b0; hostAddrSel = 1'b0; padIn = 8'hC3;
    repeat (2) @(negedge clk);
    hostCs = 1'b0;
    chk("R10 parallel blocked", modeGlobal, shReg[8'h04]);
    @(negedge clk);
    serialMode = 1'b0; serWrStb = 1'b1; serAddr = 8'h04; serWrData = 8'h3C;
    @(negedge clk);
    serWrStb = 1'b0;
    @(negedge clk);
    chk("R10 serial blocked", modeGlobal, shReg[8'h04]);

    // Random mix
    for (int i = 0; i < 400; i++) begin
      logic [7:0] a;
      logic [7:0] d;
      int op;
      a = pickAddr($urandom);
      d = 8'($urandom);
      op = $urandom % 4;
      burstFlag = 1'($urandom);
      compSync = 1'($urandom);
      fieldId = 3'($urandom);
      case (op)
        0: parWrite(a, d);
        1: serWrite(a, d);
        2: parRead(a, "R2 R3 random parallel");
        default: serRead(a, 2'($urandom), "R2 R3 random serial");
      endcase
      if (op < 2) begin
        @(negedge clk);
        chkModes("R2 random");
      end
    end

    // R11: second reset clears written state
    parWrite(8'h22, 8'h77);
    serWrite(8'h0E, 8'h3C);
    @(negedge clk);
    rstN = 1'b0;
    for (int i = 0; i < 256; i++) shReg[i] = 8'h00;
    gpSh = 4'h0;
    @(negedge clk);
    rstN = 1'b1;
    chkModes("R11 rereset");
    serRead(8'h0E, 2'b00, "R11 gp cleared");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule